// File: doc/BRIEF.md
# Queued Serial Transmit and Receive Buffer

This block sits between a processor register port and a byte-level serializer and deserializer. It holds a sixteen-frame transmit queue and a sixteen-frame receive queue. Each queue is split into a top half (frames 0 to 7) and a bottom half (frames 8 to 15). Software refills or drains one half while the hardware works on the other half. A per-half flag reports when a half has been sent or filled. Five flags, each with its own enable bit, are merged into one registered interrupt request.

A control bit chooses the transmit mode. With the queue off, a single holding register sends one byte per write. With the queue on, frames are sent from a transmit pointer up to a programmable last index, and the done flag means that the whole run is finished. A second control bit chooses between a single receive register and the receive queue. The transmit pointer can be read at any time, but a write to it takes effect only while the test-mode input is high. Baud timing and bit framing belong to the serializer and are outside this block.

Top module: `qser_buf`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `irq` is 0 and `tx_valid` is 0.
- R2: With the transmit queue disabled (control bit 0 = 0), a write to the data register (address 2) presents the byte on `tx_data` with `tx_valid` high until `tx_ready` is seen. The done flag (status bit 4) is then set.
- R3: Writing control bit 0 from 0 to 1 starts the queue at frame 0. Frames are offered in index order, one per accepted handshake. The pointer (control bits 15:12) advances by one per accepted frame, wraps from 15 to 0, and holds while `tx_ready` is low.
- R4: Queued transmission stops after the frame whose index equals the last-index field (control bits 11:8). The done flag sets and `tx_valid` drops. A new start clears the done flag and both half-empty flags.
- R5: The transmit top-empty flag (status bit 2) sets when frame 7, or the last frame if it lies in 0–7, is accepted. The bottom-empty flag (status bit 3) sets in the same way for frame 15, or a last frame in 8–15.
- R6: A control write changes the transmit pointer only while `test_mode` is 1. Otherwise the pointer field of the write is ignored. A test-mode pointer write takes priority over the reset of the pointer at a start.
- R7: With the receive queue enabled (control bit 1), each received byte is stored at the receive write pointer (status bits 11:8), which then advances and wraps from 15 to 0. Storing frame 7 sets the top-full flag (status bit 0). Storing frame 15 sets the bottom-full flag (status bit 1).
- R8: A byte that arrives for a half whose full flag is set is dropped. The write pointer does not move, and the sticky overrun flag (status bit 5) is set.
- R9: Status flags are cleared by writing 1 to their bit. A 0 bit leaves its flag unchanged.
- R10: `irq` is, one cycle later, the OR of each flag ANDed with its enable. The enables are control bit 2 (receive top full), bit 3 (receive bottom full), bit 4 (transmit top empty), bit 5 (transmit bottom empty) and bit 6 (done). Clearing an enable removes the request but leaves the flag set.
- R11: With the receive queue disabled, a received byte is stored in the single receive register, read at address 2, and the receive write pointer does not move.
- R12: While the transmit queue is enabled, a write to the data register is ignored and never produces a transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | Allows control writes to load the transmit pointer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: 0 control, 1 status, 2 data, 32–47 transmit queue, 48–63 receive queue |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| tx_valid | output | 1 | A byte is offered to the serializer |
| tx_ready | input | 1 | The serializer takes the offered byte |
| tx_data | output | 8 | Offered byte |
| rx_valid | input | 1 | A byte from the deserializer is present this cycle |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle: the transmit pointer holds while the serializer stalls and steps by one on each accepted frame; the run stops, with done set, after the last index; the pointer is locked outside test mode; the receive pointer wraps; a blocked byte sets overrun without moving the pointer; and the interrupt is quiet whenever all enables are zero. Other behaviour can only be shown by the bench's scenarios. These are the order and contents of the frames sent under random serializer stalls, the exact points where the half flags rise for full and short runs, the clear-on-one status writes, the two single-register paths, and the data-register write that is ignored in queued mode.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
   localparam int REG_W      = 16;
   // control register fields
   localparam int C_QTX      = 0;
   localparam int C_QRX      = 1;
   localparam int C_IE_RXT   = 2;
   localparam int C_IE_DONE  = 6;
   localparam int C_LAST_LSB = 8;
   localparam int C_PTR_LSB  = 12;
   // status register fields
   localparam int S_RXT      = 0;
   localparam int S_RXB      = 1;
   localparam int S_TXT      = 2;
   localparam int S_TXB      = 3;
   localparam int S_DONE     = 4;
   localparam int S_OVR      = 5;
   localparam int S_WPTR_LSB = 8;
   localparam int NFLAG      = 5;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/qsb_tx.sv
module qsb_tx #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_en,
   input  logic              q_start,
   input  logic [PW-1:0]     last,
   input  logic              ptr_wr,
   input  logic [PW-1:0]     ptr_wdata,
   input  logic              sdr_wr,
   input  logic [DATA_W-1:0] sdr_wdata,
   input  logic              mem_we,
   input  logic [PW-1:0]     mem_idx,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] mem_rdata,
   input  logic [2:0]        clr,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic [PW-1:0]     ptr,
   output logic [1:0]        half_empty,
   output logic              done
);
   localparam int HALF = DEPTH / 2;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] sdr;
   logic              pend;
   logic              fin;
   logic              acc;
   logic              q_acc;
   logic              done_set;

   assign tx_valid  = q_en ? !fin : pend;
   assign tx_data   = q_en ? mem[ptr] : sdr;
   assign acc       = tx_valid && tx_ready;
   assign q_acc     = q_en && acc;
   assign mem_rdata = mem[mem_idx];
   assign done_set  = acc && (q_en ? (ptr == last) : 1'b1);

   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_idx] <= mem_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         fin  <= 1'b0;
         pend <= 1'b0;
         sdr  <= '0;
      end else begin
         if (ptr_wr)       ptr <= ptr_wdata;
         else if (q_start) ptr <= '0;
         else if (q_acc)   ptr <= ptr + 1'b1;

         if (q_start)                    fin <= 1'b0;
         else if (q_acc && ptr == last)  fin <= 1'b1;

         if (sdr_wr && !q_en) begin
            sdr  <= sdr_wdata;
            pend <= 1'b1;
         end else if (q_start || (!q_en && acc)) begin
            pend <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  done <= 1'b0;
      else if (done_set)                           done <= 1'b1;
      else if (q_start || clr[2] || (sdr_wr && !q_en)) done <= 1'b0;
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int unsigned BND = (h + 1) * HALF - 1;
      logic set_e;
      logic flag_r;
      assign set_e = q_acc && (ptr[PW-1] == 1'(h)) &&
                     ((ptr == PW'(BND)) || (ptr == last));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                flag_r <= 1'b0;
         else if (set_e)            flag_r <= 1'b1;
         else if (q_start || clr[h]) flag_r <= 1'b0;
      end
      assign half_empty[h] = flag_r;
   end

   // R3: pointer holds while the serializer stalls in queued mode
   a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      q_en && tx_valid && !tx_ready && !ptr_wr |=> $stable(ptr));
   // R3: pointer steps by one per accepted frame
   a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      q_acc && !ptr_wr |=> ptr == PW'($past(ptr) + 1'b1));
   // R4: the run ends after the last index with done set
   a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
      q_acc && ptr == last |=> done && !tx_valid);
endmodule

// File: rtl/qsb_rx.sv
module qsb_rx #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_en,
   input  logic              q_start,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [2:0]        clr,
   input  logic [PW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rdr,
   output logic [PW-1:0]     wptr,
   output logic [1:0]        half_full,
   output logic              overrun
);
   localparam int HALF = DEPTH / 2;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              hsel;
   logic              blocked;
   logic              q_wr;

   assign hsel    = wptr[PW-1];
   assign blocked = half_full[hsel];
   assign q_wr    = q_en && rx_valid && !blocked;
   assign rd_data = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (q_wr) mem[wptr] <= rx_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rdr     <= '0;
         overrun <= 1'b0;
      end else begin
         if (q_start)   wptr <= '0;
         else if (q_wr) wptr <= wptr + 1'b1;

         if (!q_en && rx_valid) rdr <= rx_data;

         if (q_en && rx_valid && blocked) overrun <= 1'b1;
         else if (clr[2])                 overrun <= 1'b0;
      end
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int unsigned BND = (h + 1) * HALF - 1;
      logic set_f;
      logic flag_r;
      assign set_f = q_wr && (hsel == 1'(h)) && (wptr == PW'(BND));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_r <= 1'b0;
         else if (set_f)  flag_r <= 1'b1;
         else if (clr[h]) flag_r <= 1'b0;
      end
      assign half_full[h] = flag_r;
   end

   // R8: a byte for a full half is dropped and flagged
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      q_en && rx_valid && blocked && !q_start |=> overrun && $stable(wptr));
   // R7: the write pointer wraps from the final location to zero
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      q_wr && wptr == PW'(DEPTH - 1) |=> wptr == '0);
   // R7: storing the top boundary frame marks the top half full
   a_r7_top_fill: assert property (@(posedge clk) disable iff (!rst_n)
      q_wr && wptr == PW'(HALF - 1) |=> half_full[0]);
endmodule

// File: rtl/qsb_irq.sv
module qsb_irq #(
   parameter int N          = 5,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] enables,
   output logic         irq
);
   logic req;

   if (N < 1) begin : g_bad_n
      $error("qsb_irq: N must be at least 1");
   end

   assign req = |(flags & enables);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= req;
      end
   end else begin : g_comb
      assign irq = req;
   end
endmodule

// File: rtl/qser_buf.sv
module qser_buf
   import qsb_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter bit IRQ_REG = 1'b1,
   localparam int PW     = $clog2(DEPTH),
   localparam int AW     = PW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic              reg_we,
   input  logic [AW-1:0]     reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              irq
);
   localparam logic [REG_W-1:0] CTRL_MASK =
      REG_W'(7'h7F) | (REG_W'((1 << PW) - 1) << C_LAST_LSB);

   if (!(DEPTH == 8 || DEPTH == 16)) begin : g_bad_depth
      $error("qser_buf: DEPTH must be 8 or 16");
   end
   if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_width
      $error("qser_buf: DATA_W must fit the register width");
   end

   logic [REG_W-1:0]  ctrl_q;
   reg_sel_e          rsel;
   logic              sel_txq;
   logic              sel_rxq;
   logic              wr_ctrl;
   logic              wr_stat;
   logic              tx_start;
   logic              rx_start;
   logic [DATA_W-1:0] txq_rd;
   logic [DATA_W-1:0] rxq_rd;
   logic [DATA_W-1:0] rdr;
   logic [PW-1:0]     tx_ptr;
   logic [PW-1:0]     rx_wptr;
   logic [1:0]        tx_empty;
   logic [1:0]        rx_full;
   logic              tx_done;
   logic              rx_ovr;
   logic [NFLAG-1:0]  flags;

   assign sel_txq = reg_addr[AW-1:AW-2] == 2'b10;
   assign sel_rxq = reg_addr[AW-1:AW-2] == 2'b11;

   always_comb begin
      rsel = REG_NONE;
      if (reg_addr[AW-1:AW-2] == 2'b00 && reg_addr[AW-3:2] == '0) begin
         case (reg_addr[1:0])
            2'd0:    rsel = REG_CTRL;
            2'd1:    rsel = REG_STAT;
            2'd2:    rsel = REG_DATA;
            default: rsel = REG_NONE;
         endcase
      end
   end

   assign wr_ctrl  = reg_we && (rsel == REG_CTRL);
   assign wr_stat  = reg_we && (rsel == REG_STAT);
   assign tx_start = wr_ctrl && reg_wdata[C_QTX] && !ctrl_q[C_QTX];
   assign rx_start = wr_ctrl && reg_wdata[C_QRX] && !ctrl_q[C_QRX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
   end

   qsb_tx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_en       (ctrl_q[C_QTX]),
      .q_start    (tx_start),
      .last       (ctrl_q[C_LAST_LSB +: PW]),
      .ptr_wr     (wr_ctrl && test_mode),
      .ptr_wdata  (reg_wdata[C_PTR_LSB +: PW]),
      .sdr_wr     (reg_we && (rsel == REG_DATA)),
      .sdr_wdata  (reg_wdata[DATA_W-1:0]),
      .mem_we     (reg_we && sel_txq),
      .mem_idx    (reg_addr[PW-1:0]),
      .mem_wdata  (reg_wdata[DATA_W-1:0]),
      .mem_rdata  (txq_rd),
      .clr        ({wr_stat && reg_wdata[S_DONE], wr_stat && reg_wdata[S_TXB],
                    wr_stat && reg_wdata[S_TXT]}),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .ptr        (tx_ptr),
      .half_empty (tx_empty),
      .done       (tx_done)
   );

   qsb_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_en      (ctrl_q[C_QRX]),
      .q_start   (rx_start),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .clr       ({wr_stat && reg_wdata[S_OVR], wr_stat && reg_wdata[S_RXB],
                   wr_stat && reg_wdata[S_RXT]}),
      .rd_idx    (reg_addr[PW-1:0]),
      .rd_data   (rxq_rd),
      .rdr       (rdr),
      .wptr      (rx_wptr),
      .half_full (rx_full),
      .overrun   (rx_ovr)
   );

   assign flags = {tx_done, tx_empty[1], tx_empty[0], rx_full[1], rx_full[0]};

   qsb_irq #(.N(NFLAG), .REGISTERED(IRQ_REG)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flags),
      .enables (ctrl_q[C_IE_DONE:C_IE_RXT]),
      .irq     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (sel_txq) begin
         reg_rdata[DATA_W-1:0] = txq_rd;
      end else if (sel_rxq) begin
         reg_rdata[DATA_W-1:0] = rxq_rd;
      end else begin
         case (rsel)
            REG_CTRL: begin
               reg_rdata = ctrl_q;
               reg_rdata[C_PTR_LSB +: PW] = tx_ptr;
            end
            REG_STAT: begin
               reg_rdata[S_RXT]  = rx_full[0];
               reg_rdata[S_RXB]  = rx_full[1];
               reg_rdata[S_TXT]  = tx_empty[0];
               reg_rdata[S_TXB]  = tx_empty[1];
               reg_rdata[S_DONE] = tx_done;
               reg_rdata[S_OVR]  = rx_ovr;
               reg_rdata[S_WPTR_LSB +: PW] = rx_wptr;
            end
            REG_DATA: reg_rdata[DATA_W-1:0] = rdr;
            default:  reg_rdata = '0;
         endcase
      end
   end

   // R6: outside test mode a control write leaves the pointer alone
   a_r6_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && !test_mode && ctrl_q[C_QTX] && !(tx_valid && tx_ready)
      |=> $stable(tx_ptr));

   if (IRQ_REG) begin : g_irq_chk
      // R10: no request while every enable is clear
      a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_q[C_IE_DONE:C_IE_RXT] == '0 |=> !irq);
   end
endmodule

// File: tb/test_qser_buf.sv
module test_qser_buf;
   localparam int CLK_PERIOD = 10;
   localparam int NQ         = 16;
   localparam logic [5:0] A_CTRL = 6'd0;
   localparam logic [5:0] A_STAT = 6'd1;
   localparam logic [5:0] A_DATA = 6'd2;
   localparam logic [5:0] A_TXQ  = 6'd32;
   localparam logic [5:0] A_RXQ  = 6'd48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        test_mode = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] txm [NQ];
   logic [7:0] rxm [NQ];
   logic [15:0] rv;

   always #(CLK_PERIOD / 2) clk = ~clk;

   qser_buf i_qser_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_data   (tx_data),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .irq       (irq)
   );

   function automatic logic [15:0] ctrl_word(input bit qtx, input bit qrx,
         input logic [4:0] ie, input int last, input int ptr);
      return {4'(ptr), 4'(last), 1'b0, ie, qrx, qtx};
   endfunction

   // expected {done, bottom-empty, top-empty} after sending first..last
   function automatic logic [2:0] exp_tx_flags(input int first, input int last);
      logic top = 1'b0;
      logic bot = 1'b0;
      for (int i = first; i <= last; i++) begin
         if (i < NQ / 2 && (i == NQ / 2 - 1 || i == last)) top = 1'b1;
         if (i >= NQ / 2 && (i == NQ - 1 || i == last)) bot = 1'b1;
      end
      return {1'b1, bot, top};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic run_queue(input string req, input int n, input int first, input bit rnd);
      int got = 0;
      for (int cyc = 0; cyc < 400 && got < n; cyc++) begin
         @(negedge clk);
         tx_ready = rnd ? 1'($urandom_range(1, 0)) : 1'b1;
         #1;
         if (tx_valid && tx_ready) begin
            check(req, tx_data, txm[(first + got) % NQ]);
            got++;
         end
      end
      @(negedge clk);
      tx_ready = 1'b0;
      check(req, got, n);
      check(req, tx_valid, 1'b0);
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NQ; i++) txm[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, rv); check("R1 ctrl", rv, 16'h0);
      rd(A_STAT, rv); check("R1 status", rv, 16'h0);
      check("R1 irq", irq, 1'b0);
      check("R1 tx_valid", tx_valid, 1'b0);

      // R2 single-register transmit
      wr(A_DATA, 16'h00A5);
      check("R2 valid", tx_valid, 1'b1);
      check("R2 data", tx_data, 8'hA5);
      repeat (3) @(negedge clk);
      check("R2 held", {tx_valid, tx_data}, {1'b1, 8'hA5});
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      check("R2 sent", tx_valid, 1'b0);
      rd(A_STAT, rv); check("R2 done", rv[4], 1'b1);
      // R9 clear-on-one
      wr(A_STAT, 16'h0000);
      rd(A_STAT, rv); check("R9 zero keeps", rv[4], 1'b1);
      wr(A_STAT, 16'h0010);
      rd(A_STAT, rv); check("R9 one clears", rv[4], 1'b0);

      // R3 full queue with random stalls
      for (int i = 0; i < NQ; i++) wr(A_TXQ + 6'(i), {8'h0, txm[i]});
      rd(A_TXQ + 6'd5, rv); check("R3 queue readback", rv, {8'h0, txm[5]});
      wr(A_CTRL, ctrl_word(1, 0, 5'b00100, 15, 0));
      run_queue("R3 order", 16, 0, 1'b1);
      rd(A_CTRL, rv); check("R3 ptr wraps", rv, ctrl_word(1, 0, 5'b00100, 15, 0));
      rd(A_STAT, rv); check("R5 full run flags", rv[4:2], exp_tx_flags(0, 15));
      check("R10 irq enabled", irq, 1'b1);
      wr(A_CTRL, ctrl_word(1, 0, 5'b00000, 15, 0));
      @(negedge clk);
      check("R10 irq masked", irq, 1'b0);
      rd(A_STAT, rv); check("R10 flag kept", rv[2], 1'b1);

      // R4 short run stops at last index
      wr(A_CTRL, 16'h0);
      wr(A_CTRL, ctrl_word(1, 0, 5'b0, 5, 0));
      run_queue("R4 short run", 6, 0, 1'b0);
      rd(A_STAT, rv); check("R5 short flags", rv[4:2], exp_tx_flags(0, 5));
      rd(A_CTRL, rv); check("R4 ptr after stop", rv[15:12], 4'd6);

      // R6 pointer writable only in test mode
      wr(A_CTRL, ctrl_word(1, 0, 5'b0, 5, 9));
      rd(A_CTRL, rv); check("R6 locked", rv[15:12], 4'd6);
      test_mode = 1'b1;
      wr(A_CTRL, ctrl_word(1, 0, 5'b0, 5, 3));
      rd(A_CTRL, rv); check("R6 test write", rv[15:12], 4'd3);
      check("R6 no restart", tx_valid, 1'b0);
      wr(A_CTRL, 16'h0);
      wr(A_CTRL, ctrl_word(1, 0, 5'b0, 13, 12));
      test_mode = 1'b0;
      run_queue("R6 start at 12", 2, 12, 1'b1);
      rd(A_STAT, rv); check("R5 bottom only", rv[4:2], exp_tx_flags(12, 13));

      // R12 data write ignored in queued mode
      wr(A_DATA, 16'h003C);
      tx_ready = 1'b1;
      repeat (2) @(negedge clk);
      check("R12 no send", tx_valid, 1'b0);
      tx_ready = 1'b0;
      wr(A_CTRL, 16'h0);
      check("R12 nothing pending", tx_valid, 1'b0);

      // R11 single receive register
      push(8'h77);
      rd(A_DATA, rv); check("R11 rdr", rv, 16'h0077);
      rd(A_STAT, rv); check("R11 wptr still", rv[11:8], 4'd0);

      // R7 receive queue fill
      wr(A_CTRL, ctrl_word(0, 1, 5'b00001, 0, 0));
      for (int i = 0; i < NQ / 2; i++) begin
         rxm[i] = 8'($urandom);
         push(rxm[i]);
      end
      rd(A_STAT, rv); check("R7 top full", {rv[11:8], rv[1:0]}, {4'd8, 2'b01});
      @(negedge clk);
      check("R10 rx irq", irq, 1'b1);
      for (int i = 0; i < NQ / 2; i++) begin
         rd(A_RXQ + 6'(i), rv); check("R7 stored", rv, {8'h0, rxm[i]});
      end
      for (int i = NQ / 2; i < NQ; i++) begin
         rxm[i] = 8'($urandom);
         push(rxm[i]);
      end
      rd(A_STAT, rv); check("R7 wrap and bottom", {rv[11:8], rv[1:0]}, {4'd0, 2'b11});
      rd(A_RXQ + 6'd15, rv); check("R7 last loc", rv, {8'h0, rxm[15]});

      // R8 overrun
      push(8'hEE);
      rd(A_STAT, rv); check("R8 overrun", {rv[11:8], rv[5]}, {4'd0, 1'b1});
      rd(A_RXQ, rv); check("R8 dropped", rv, {8'h0, rxm[0]});

      // R9 clear top and overrun, bottom stays
      wr(A_STAT, 16'h0021);
      push(8'h5A);
      rd(A_STAT, rv); check("R9 selective clear", {rv[11:8], rv[5], rv[1:0]}, {4'd1, 1'b0, 2'b10});
      rd(A_RXQ, rv); check("R7 after clear", rv, 16'h005A);

      finish_up();
   end
endmodule